// File: doc/BRIEF.md
# Write-Back Set-Associative Data Cache

This block sits between a processor's load/store port and a slower backing memory. It keeps recently used 64-byte lines in an 8-way set-associative store. Each line entry carries its data, a tag and valid and dirty bits. A load or store that finds its line completes one cycle after it is accepted, and no memory traffic results.

A miss picks a victim way in the indexed set. An empty way is taken first. When every way is occupied, a per-set tree pseudo-LRU picks the victim. If the victim holds modified data, its whole line is sent to memory first, and that transfer must be acknowledged before the refill is requested. Stores follow a write-back, write-allocate policy. A store miss therefore fetches the full line and then merges the store word into it. Modified data leaves the cache only when its line is evicted.

The processor side carries one request at a time. The memory side moves whole lines, and each transfer is held until memory acknowledges it.

Top module: `wb_dcache`

## Requirements
- R1: Reset clears every valid and dirty bit. After reset, `cpuReady` and `memReq` are low, and the first access to any line misses.
- R2: Byte address bits [5:0] are the line offset, and bits [5:2] select one of 16 words. The next log2(SETS) bits select the set, and the remaining upper bits form the tag. Every memory address has bits [5:0] equal to zero.
- R3: A load hit raises `cpuReady` exactly one cycle after the request is accepted. `cpuRdata` then holds the latest value stored to that word, and `memReq` stays low.
- R4: A store hit updates only the cached word and marks the line dirty. It completes one cycle after acceptance and causes no memory write.
- R5: A load miss with a clean or empty victim issues one line read and no write. `cpuReady` rises in the cycle after the read acknowledge, with the requested word.
- R6: A store miss reads the whole line from memory and then merges the store word. The other 15 words of that line keep the memory values.
- R7: A dirty victim is written back as a full line at the victim's own line address, holding its latest contents. The refill read is issued in the cycle after the write-back acknowledge and never before it.
- R8: A clean victim is dropped without any memory write.
- R9: Within a set, an empty way is always chosen before an occupied one. Eight distinct lines of one set therefore all stay resident.
- R10: When no way is empty, the victim comes from a per-set tree pseudo-LRU. After the eight ways are touched in order 0 to 7, the line touched first is evicted. The most recently touched line is never the victim.
- R11: `memReq`, `memWe` and `memAddr` stay stable from the rise of `memReq` until the cycle in which `memAck` is seen.
- R12: `cpuReady` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request present (accepted when the cache is idle) |
| cpuAddr | input | ADDR_W | Byte address of the request |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuWdata | input | WORD_W | Store data |
| cpuReady | output | 1 | One-cycle completion pulse |
| cpuRdata | output | WORD_W | Load data, valid while cpuReady is high |
| memReq | output | 1 | Line transfer request, held until memAck |
| memWe | output | 1 | 1 = line write-back, 0 = line read |
| memAddr | output | ADDR_W | Line-aligned byte address |
| memWdata | output | LINE_BYTES*8 | Line being written back |
| memAck | input | 1 | Memory completes the transfer in this cycle |
| memRdata | input | LINE_BYTES*8 | Refill line, valid with memAck |

## Verification
The bench fills one set to its full eight ways and then adds a ninth line. This exposes a design that prefers occupied ways over empty ones, or that evicts a recently touched line: unexpected refills would then appear on lines that should still hit. A dirty eviction is checked for the order of write-back and refill, for the line address used, and for whether the latest stored words reach memory. A cache that dropped dirty data or refilled first would later return stale words. Store misses are swept across whole lines to catch a merge that clobbers neighbouring words or skips the fetch. A long mixed sweep on one set compares every load with a model of the processor's view, and compares every write-back with the same model.

// File: rtl/dc_pkg.sv
package dc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_WBACK  = 2'd2,
    ST_FILL   = 2'd3
  } dcState_t;

  typedef struct packed {
    logic latchReq;
    logic hitWrite;
    logic touch;
    logic latchVictim;
    logic fillWrite;
    logic wbSel;
  } dcStrobes_t;

endpackage

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuValid,
  input  logic       hit,
  input  logic       reqWe,
  input  logic       victimDirty,
  input  logic       memAck,
  output dcStrobes_t strobes,
  output logic       cpuReady,
  output logic       memReq,
  output logic       memWe
);

  dcState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    cpuReady  = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cpuValid) begin
          strobes.latchReq = 1'b1;
          stateNext        = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (hit) begin
          cpuReady         = 1'b1;
          strobes.touch    = 1'b1;
          strobes.hitWrite = reqWe;
          stateNext        = ST_IDLE;
        end else begin
          strobes.latchVictim = 1'b1;
          stateNext           = victimDirty ? ST_WBACK : ST_FILL;
        end
      end
      ST_WBACK: begin
        memReq        = 1'b1;
        memWe         = 1'b1;
        strobes.wbSel = 1'b1;
        if (memAck) stateNext = ST_FILL;
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          strobes.fillWrite = 1'b1;
          stateNext         = ST_LOOKUP;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dc_dpath.sv
module dc_dpath
  import dc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 4,
  parameter int WAYS       = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dcStrobes_t              strobes,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic                    cpuWe,
  input  logic [WORD_W-1:0]       cpuWdata,
  input  logic [LINE_BYTES*8-1:0] memRdata,
  output logic                    hit,
  output logic                    reqWe,
  output logic                    victimDirty,
  output logic [WORD_W-1:0]       cpuRdata,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [LINE_BYTES*8-1:0] memWdata
);

  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WORDS  = LINE_W / WORD_W;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int BSEL_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W  = $clog2(WAYS);

  logic [LINE_W-1:0] dataArr  [SETS][WAYS];
  logic [TAG_W-1:0]  tagArr   [SETS][WAYS];
  logic [WAYS-1:0]   validArr [SETS];
  logic [WAYS-1:0]   dirtyArr [SETS];
  logic [WAYS-1:0]   plruArr  [SETS];

  logic [ADDR_W-1:0] reqAddr;
  logic [WORD_W-1:0] reqWdata;
  logic [WAY_W-1:0]  vicWayQ;

  logic [IDX_W-1:0]  reqIdx;
  logic [TAG_W-1:0]  reqTag;
  logic [WSEL_W-1:0] reqWsel;

  assign reqIdx  = reqAddr[OFF_W +: IDX_W];
  assign reqTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqWsel = reqAddr[BSEL_W +: WSEL_W];

  // Walk the tree from the root toward the way the bits point at.
  function automatic logic [WAY_W-1:0] plruPick(input logic [WAYS-1:0] bits);
    int n;
    n = 1;
    for (int l = 0; l < WAY_W; l++) n = 2 * n + int'(bits[n]);
    return WAY_W'(n - WAYS);
  endfunction

  // Point every node on the path of the touched way away from it.
  function automatic logic [WAYS-1:0] plruTouch(input logic [WAYS-1:0] bits,
                                                input logic [WAY_W-1:0] way);
    logic [WAYS-1:0] b;
    int n;
    b = bits;
    n = WAYS + int'(way);
    for (int l = 0; l < WAY_W; l++) begin
      b[n / 2] = (n % 2 == 0);
      n        = n / 2;
    end
    return b;
  endfunction

  logic [WAYS-1:0]  hitVec;
  logic [WAY_W-1:0] hitWay;
  logic [WAY_W-1:0] freeWay;
  logic             anyFree;
  logic [WAY_W-1:0] vicWayNow;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validArr[reqIdx][w] && (tagArr[reqIdx][w] == reqTag);
  end

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (hitVec[w]) hitWay = WAY_W'(w);
  end

  always_comb begin
    freeWay = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!validArr[reqIdx][w]) freeWay = WAY_W'(w);
  end

  assign anyFree     = ~&validArr[reqIdx];
  assign vicWayNow   = anyFree ? freeWay : plruPick(plruArr[reqIdx]);
  assign hit         = |hitVec;
  assign victimDirty = validArr[reqIdx][vicWayNow] && dirtyArr[reqIdx][vicWayNow];

  logic [LINE_W-1:0] hitLine;
  assign hitLine  = dataArr[reqIdx][hitWay];
  assign cpuRdata = hitLine[int'(reqWsel) * WORD_W +: WORD_W];
  assign memWdata = dataArr[reqIdx][vicWayQ];
  assign memAddr  = strobes.wbSel ? {tagArr[reqIdx][vicWayQ], reqIdx, OFF_W'(0)}
                                  : {reqTag, reqIdx, OFF_W'(0)};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqWe    <= 1'b0;
      reqWdata <= '0;
      vicWayQ  <= '0;
    end else begin
      if (strobes.latchReq) begin
        reqAddr  <= cpuAddr;
        reqWe    <= cpuWe;
        reqWdata <= cpuWdata;
      end
      if (strobes.latchVictim) vicWayQ <= vicWayNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validArr[s] <= '0;
        dirtyArr[s] <= '0;
        plruArr[s]  <= '0;
      end
    end else begin
      if (strobes.fillWrite) begin
        validArr[reqIdx][vicWayQ] <= 1'b1;
        dirtyArr[reqIdx][vicWayQ] <= 1'b0;
      end
      if (strobes.hitWrite) dirtyArr[reqIdx][hitWay] <= 1'b1;
      if (strobes.touch)    plruArr[reqIdx] <= plruTouch(plruArr[reqIdx], hitWay);
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.fillWrite) begin
      dataArr[reqIdx][vicWayQ] <= memRdata;
      tagArr[reqIdx][vicWayQ]  <= reqTag;
    end
    if (strobes.hitWrite)
      dataArr[reqIdx][hitWay][int'(reqWsel) * WORD_W +: WORD_W] <= reqWdata;
  end

endmodule

// File: rtl/wb_dcache.sv
module wb_dcache
  import dc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 4,
  parameter int WAYS       = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cpuValid,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic                    cpuWe,
  input  logic [WORD_W-1:0]       cpuWdata,
  output logic                    cpuReady,
  output logic [WORD_W-1:0]       cpuRdata,
  output logic                    memReq,
  output logic                    memWe,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [LINE_BYTES*8-1:0] memWdata,
  input  logic                    memAck,
  input  logic [LINE_BYTES*8-1:0] memRdata
);

  dcStrobes_t strobes;
  logic       hit;
  logic       reqWe;
  logic       victimDirty;

  dc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .hit(hit), .reqWe(reqWe),
    .victimDirty(victimDirty), .memAck(memAck), .strobes(strobes),
    .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe)
  );

  dc_dpath #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_BYTES(LINE_BYTES),
    .SETS(SETS), .WAYS(WAYS)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuAddr(cpuAddr), .cpuWe(cpuWe),
    .cpuWdata(cpuWdata), .memRdata(memRdata), .hit(hit), .reqWe(reqWe),
    .victimDirty(victimDirty), .cpuRdata(cpuRdata), .memAddr(memAddr),
    .memWdata(memWdata)
  );

endmodule

// File: rtl/dc_checker.sv
module dc_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReady,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr
);

  localparam int OFF_W = $clog2(LINE_BYTES);

  // R11
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(memAddr)));

  // R12
  a_r12_ready_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);

  // R7
  a_r7_wb_then_fill: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAck) |=> (memReq && !memWe));

  // R5
  a_r5_fill_then_ready: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memAck) |=> cpuReady);

  // R2
  a_r2_line_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[OFF_W-1:0] == '0));

  // R3
  a_r3_no_ready_during_mem: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !cpuReady);

endmodule

bind wb_dcache dc_checker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) chk_i (
  .clk(clk), .rstN(rstN), .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe),
  .memAck(memAck), .memAddr(memAddr)
);

// File: tb/wb_dcache_tb_top.sv
`timescale 1ns/1ps
module wb_dcache_tb_top;

  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int LINE_B = 64;
  localparam int SETS   = 4;
  localparam int WAYS   = 8;
  localparam int LINE_W = LINE_B * 8;
  localparam int WPL    = LINE_W / WORD_W;
  localparam int MEMW   = 4096;
  localparam int LAT    = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cpuValid = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic              cpuWe = 1'b0;
  logic [WORD_W-1:0] cpuWdata = '0;
  logic              cpuReady;
  logic [WORD_W-1:0] cpuRdata;
  logic              memReq;
  logic              memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [LINE_W-1:0] memWdata;
  logic              memAck = 1'b0;
  logic [LINE_W-1:0] memRdata = '0;

  always #4 clk = ~clk;

  wb_dcache #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_BYTES(LINE_B),
              .SETS(SETS), .WAYS(WAYS)) dut_i (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuAddr(cpuAddr), .cpuWe(cpuWe),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRdata(cpuRdata), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata)
  );

  logic [31:0] backMem  [MEMW];
  logic [31:0] procView [MEMW];
  int checks = 0;
  int fails = 0;
  int cycleNo = 0;
  int fillCnt = 0;
  int wbCnt = 0;
  int fillAckCyc = 0;
  int wbAckCyc = 0;
  logic [31:0] lastFillAddr = '0;
  logic [31:0] lastWbAddr = '0;
  bit finished = 0;

  always @(posedge clk) cycleNo <= cycleNo + 1;

  function automatic logic [31:0] initWord(int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] lineAddr(int tag, int set);
    return 32'(tag * (LINE_B * SETS) + set * LINE_B);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Backing memory: acknowledges each held request after LAT cycles.
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck = 1'b0;
      end else if (memReq) begin
        cnt++;
        if (cnt == LAT) begin
          cnt = 0;
          chk(memAddr[5:0] == 6'd0, "R2 line-aligned memory address",
              memAddr, memAddr & 32'hFFFF_FFC0);
          if (memWe) begin
            bit same;
            same = 1;
            for (int k = 0; k < WPL; k++) begin
              if (memWdata[k*32 +: 32] != procView[(memAddr >> 2) + k]) same = 0;
              backMem[(memAddr >> 2) + k] = memWdata[k*32 +: 32];
            end
            chk(same, "R7 write-back line holds latest data", memAddr, memAddr);
            wbCnt++;
            wbAckCyc = cycleNo;
            lastWbAddr = memAddr;
          end else begin
            for (int k = 0; k < WPL; k++)
              memRdata[k*32 +: 32] = backMem[(memAddr >> 2) + k];
            fillCnt++;
            fillAckCyc = cycleNo;
            lastFillAddr = memAddr;
          end
          memAck = 1'b1;
        end
      end else begin
        cnt = 0;
      end
    end
  end

  // One processor access; returns data and the cycles from acceptance to ready.
  task automatic access(input logic [31:0] addr, input bit we, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc);
    int f0;
    f0 = fillCnt;
    @(negedge clk);
    cpuValid = 1'b1;
    cpuAddr = addr;
    cpuWe = we;
    cpuWdata = wd;
    if (we) procView[addr >> 2] = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpuReady);
    rd = cpuRdata;
    cpuValid = 1'b0;
    if (!we) chk(rd == procView[addr >> 2], "R3 load data matches latest value",
                 rd, procView[addr >> 2]);
    if (fillCnt != f0)
      chk(cycleNo == fillAckCyc + 1, "R5 ready in cycle after refill ack",
          32'(cycleNo), 32'(fillAckCyc + 1));
  endtask

  initial begin
    logic [31:0] rd;
    int cyc, f0, w0;
    for (int i = 0; i < MEMW; i++) begin
      backMem[i] = initWord(i);
      procView[i] = initWord(i);
    end
    repeat (3) @(negedge clk);
    chk(!cpuReady && !memReq, "R1 outputs quiet in reset", {cpuReady, memReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!cpuReady && !memReq, "R1 outputs quiet after reset", {cpuReady, memReq}, 0);

    // Load miss after reset: one read, no write.
    access(lineAddr(0, 0) + 12, 0, 0, rd, cyc);
    chk(fillCnt == 1 && wbCnt == 0, "R1 R5 R8 first load misses with one read",
        32'(fillCnt * 16 + wbCnt), 32'h10);
    chk(lastFillAddr == lineAddr(0, 0), "R2 refill address", lastFillAddr, lineAddr(0, 0));

    // Every word of the resident line hits in one cycle.
    for (int k = 0; k < WPL; k++) begin
      access(lineAddr(0, 0) + 32'(k * 4), 0, 0, rd, cyc);
      chk(cyc == 1, "R3 load hit latency", 32'(cyc), 1);
    end
    chk(fillCnt == 1, "R3 hits cause no memory traffic", 32'(fillCnt), 1);

    // Store hit stays in the cache.
    access(lineAddr(0, 0) + 20, 1, 32'hCAFE0005, rd, cyc);
    chk(cyc == 1 && wbCnt == 0, "R4 store hit one cycle, no write", 32'(cyc * 16 + wbCnt), 16);
    access(lineAddr(0, 0) + 20, 0, 0, rd, cyc);
    chk(rd == 32'hCAFE0005, "R4 stored word read back", rd, 32'hCAFE0005);

    // Store miss: allocate then merge; whole line checked.
    f0 = fillCnt; w0 = wbCnt;
    access(lineAddr(1, 1) + 28, 1, 32'hBEEF0007, rd, cyc);
    chk(fillCnt == f0 + 1 && wbCnt == w0, "R6 store miss fetches line first",
        32'(fillCnt - f0), 1);
    for (int k = 0; k < WPL; k++) begin
      access(lineAddr(1, 1) + 32'(k * 4), 0, 0, rd, cyc);
      chk(cyc == 1, "R6 merged line resident", 32'(cyc), 1);
    end

    // Fill set 0 with tags 1..7: empty ways used, nothing evicted.
    w0 = wbCnt;
    for (int t = 1; t < WAYS; t++) access(lineAddr(t, 0), 0, 0, rd, cyc);
    chk(wbCnt == w0, "R9 empty ways taken before occupied", 32'(wbCnt - w0), 0);
    f0 = fillCnt;
    for (int t = 0; t < WAYS; t++) access(lineAddr(t, 0) + 4, 0, 0, rd, cyc);
    chk(fillCnt == f0, "R9 eight lines of one set resident", 32'(fillCnt - f0), 0);

    // Ways touched 0..7: ninth line evicts tag 0 (dirty): write-back then refill.
    f0 = fillCnt; w0 = wbCnt;
    access(lineAddr(8, 0), 0, 0, rd, cyc);
    chk(wbCnt == w0 + 1 && lastWbAddr == lineAddr(0, 0),
        "R10 R7 first-touched dirty line written back", lastWbAddr, lineAddr(0, 0));
    chk(wbAckCyc < fillAckCyc && fillCnt == f0 + 1, "R7 write-back acked before refill",
        32'(wbAckCyc), 32'(fillAckCyc));
    f0 = fillCnt;
    access(lineAddr(8, 0) + 8, 0, 0, rd, cyc);
    access(lineAddr(1, 0) + 8, 0, 0, rd, cyc);
    chk(fillCnt == f0, "R10 recent lines kept", 32'(fillCnt - f0), 0);
    // Tree state now selects way 4 (tag 4, clean).
    w0 = wbCnt;
    access(lineAddr(0, 0) + 20, 0, 0, rd, cyc);
    chk(rd == 32'hCAFE0005, "R7 written-back store survives in memory", rd, 32'hCAFE0005);
    chk(wbCnt == w0, "R8 clean victim dropped silently", 32'(wbCnt - w0), 0);
    f0 = fillCnt;
    access(lineAddr(4, 0), 0, 0, rd, cyc);
    chk(fillCnt == f0 + 1, "R10 pseudo-LRU victim was tag 4", 32'(fillCnt - f0), 1);

    // Set 2: eight store misses, then a ninth evicting a dirty line.
    w0 = wbCnt;
    for (int t = 0; t < WAYS; t++)
      access(lineAddr(t, 2) + 32'(t * 4), 1, 32'h2200_0000 + 32'(t), rd, cyc);
    chk(wbCnt == w0, "R6 store misses into empty ways", 32'(wbCnt - w0), 0);
    access(lineAddr(8, 2) + 60, 1, 32'h2200_0008, rd, cyc);
    chk(wbCnt == w0 + 1 && lastWbAddr == lineAddr(0, 2), "R7 dirty victim address",
        lastWbAddr, lineAddr(0, 2));
    access(lineAddr(0, 2), 0, 0, rd, cyc);
    chk(rd == 32'h2200_0000, "R7 dirty data reached memory", rd, 32'h2200_0000);

    // Mixed sweep on set 3 against the processor-view model.
    for (int i = 0; i < 120; i++) begin
      access(lineAddr((i * 5) % 11, 3) + 32'(((i * 7) % WPL) * 4), (i % 3) == 0,
             32'h3300_0000 + 32'(i), rd, cyc);
    end
    for (int t = 0; t < 11; t++)
      for (int k = 0; k < WPL; k += 5) access(lineAddr(t, 3) + 32'(k * 4), 0, 0, rd, cyc);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule